// File: doc/BRIEF.md
# Per-Pin Secure Access Filter

This block is the register-bank front end of a general-purpose I/O controller. It accepts one bus access per cycle: a word address, a read/write flag, write data and a non-secure attribute. For each access and each bit, it decides whether a read returns the stored value or zero, whether a write lands, and whether a bus error is raised. The register file is held inside the block: control words, pin direction, pin output level, pin configuration, multiplexer enable, a sampled pin input, a per-pin non-secure enable word and a change-check mask.

A static mode pin selects between two configurations. In the fully secure configuration, every non-secure access is refused with an error. In the mixed configuration, the non-secure enable word opens individual pins to non-secure software. Secure software may edit that word. When an edit touches a bit that the change-check mask selects, a single notification flag is set. That flag, gated by an enable bit, drives the interrupt pin.

The bus has no back-pressure. Every access completes in the cycle it is presented, so there is no ready signal. `bus_rdata` and `bus_err` are combinational in the access cycle, and writes take effect at the next rising clock edge. The pin-facing outputs are plain registered levels.

Top module: `psaf_top`

## Requirements
- R1: A secure access (bus_ns=0) to any mapped word is granted in both modes. A read returns the full stored value, a write updates every bit, and bus_err stays 0. After reset all registers, the flag and the enable bit read 0.
- R2: With mix_mode=0, a non-secure read at any address returns 0 and raises bus_err in the same cycle.
- R3: With mix_mode=0, a non-secure write at any address changes nothing and raises bus_err.
- R4: With mix_mode=1, the change-check mask (word 3), enable-clear (word 4), enable-set (word 5) and flag (word 6) words are fully open to non-secure reads and writes.
- R5: With mix_mode=1, the control word (0) and event-control word (1) read 0 and ignore writes from non-secure accesses, without an error.
- R6: Non-secure reads of the non-secure enable word (2) return its value. Non-secure writes to it are dropped without an error.
- R7: With mix_mode=1, a non-secure access to direction (8), output (12), input (16), pin configuration (17) or multiplexer enable (18) sees only the bits whose enable bit is 1. Other bits read 0 and are not written. No error is raised.
- R8: Clear, set and toggle aliases of direction (9, 10, 11) and output (13, 14, 15) apply the per-bit mask to the write data before the operation, so a non-secure alias write never moves a pin whose enable bit is 0.
- R9: A granted write to word 2 that changes any bit also set in the change-check mask sets the flag (bit 0 of word 6). Changes only in unmasked bits leave the flag alone.
- R10: Writing 1 to bit 0 of word 6 clears the flag. Writing 1 to bit 0 of word 5 sets the enable bit, and writing 1 to bit 0 of word 4 clears it. Both words 4 and 5 read the enable bit at bit 0. irq equals flag AND enable.
- R11: Unmapped words (7 and 19 to 31) read 0 and raise no error for secure accesses and for non-secure accesses in mixed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mix_mode | input | 1 | 1 = mixed configuration, 0 = fully secure |
| bus_sel | input | 1 | Access present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ns | input | 1 | 1 = non-secure initiator |
| bus_addr | input | AW | Word address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, masked |
| bus_err | output | 1 | Bus error for this access |
| pin_in | input | W | Sampled pin levels |
| ctrl_o | output | W | Control word |
| evctl_o | output | W | Event-control word |
| dir_o | output | W | Pin direction |
| out_o | output | W | Pin output level |
| pcfg_o | output | W | Pin configuration bits |
| pmux_o | output | W | Multiplexer enable bits |
| irq | output | 1 | Change-notification interrupt |

## Verification
A seeded random stream mixes reads and writes with secure and non-secure attributes across every word, both mapped and unmapped, in each mode. It is checked against a bench model, which separates register classes by their differing read-back, write and error results. Random enable words produce mixed per-bit masks, so a bit leaking across the mask on plain writes or aliases shows up as a wrong direction or output value. Directed steps set the change-check mask and edit the enable word inside and outside it, which tells a correctly masked change detector from one that fires on any edit. They then walk the enable bit and the flag-clear path so that the interrupt gating is visible at the pin.

// File: rtl/psaf_pkg.sv
package psaf_pkg;
  // word offsets
  localparam int OFF_CTRL  = 0;
  localparam int OFF_EVCTL = 1;
  localparam int OFF_NSEN  = 2;
  localparam int OFF_CHK   = 3;
  localparam int OFF_ICLR  = 4;
  localparam int OFF_ISET  = 5;
  localparam int OFF_IFLAG = 6;
  localparam int OFF_DIR   = 8;
  localparam int OFF_DIRC  = 9;
  localparam int OFF_DIRS  = 10;
  localparam int OFF_DIRT  = 11;
  localparam int OFF_OUT   = 12;
  localparam int OFF_OUTC  = 13;
  localparam int OFF_OUTS  = 14;
  localparam int OFF_OUTT  = 15;
  localparam int OFF_IN    = 16;
  localparam int OFF_PCFG  = 17;
  localparam int OFF_PMUX  = 18;

  // alias groups keep WRITE, CLR, SET, TGL in sequence
  typedef enum logic [4:0] {
    R_CTRL, R_EVCTL, R_NSEN, R_CHK, R_ICLR, R_ISET, R_IFLAG,
    R_DIR, R_DIRC, R_DIRS, R_DIRT,
    R_OUT, R_OUTC, R_OUTS, R_OUTT,
    R_IN, R_PCFG, R_PMUX, R_NONE
  } rid_e;

  typedef enum logic [2:0] {CL_SEC, CL_NSEN, CL_OPEN, CL_PIN, CL_NONE} cls_e;

  typedef enum logic [1:0] {AOP_WRITE, AOP_CLR, AOP_SET, AOP_TGL} aop_e;
endpackage

// File: rtl/psaf_decode.sv
module psaf_decode
  import psaf_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] addr,
  output rid_e          rid,
  output cls_e          cls
);
  always_comb begin
    case (int'(addr))
      OFF_CTRL:  rid = R_CTRL;
      OFF_EVCTL: rid = R_EVCTL;
      OFF_NSEN:  rid = R_NSEN;
      OFF_CHK:   rid = R_CHK;
      OFF_ICLR:  rid = R_ICLR;
      OFF_ISET:  rid = R_ISET;
      OFF_IFLAG: rid = R_IFLAG;
      OFF_DIR:   rid = R_DIR;
      OFF_DIRC:  rid = R_DIRC;
      OFF_DIRS:  rid = R_DIRS;
      OFF_DIRT:  rid = R_DIRT;
      OFF_OUT:   rid = R_OUT;
      OFF_OUTC:  rid = R_OUTC;
      OFF_OUTS:  rid = R_OUTS;
      OFF_OUTT:  rid = R_OUTT;
      OFF_IN:    rid = R_IN;
      OFF_PCFG:  rid = R_PCFG;
      OFF_PMUX:  rid = R_PMUX;
      default:   rid = R_NONE;
    endcase
  end

  always_comb begin
    case (rid)
      R_CTRL, R_EVCTL:                cls = CL_SEC;
      R_NSEN:                         cls = CL_NSEN;
      R_CHK, R_ICLR, R_ISET, R_IFLAG: cls = CL_OPEN;
      R_NONE:                         cls = CL_NONE;
      default:                        cls = CL_PIN;
    endcase
  end
endmodule

// File: rtl/psaf_gate.sv
module psaf_gate
  import psaf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         mix_mode,
  input  logic         ns,
  input  cls_e         cls,
  input  logic [W-1:0] nsen,
  output logic [W-1:0] rd_mask,
  output logic [W-1:0] wr_mask,
  output logic         blk_err
);
  always_comb begin
    rd_mask = '1;
    wr_mask = '1;
    blk_err = 1'b0;
    if (cls == CL_NONE) begin
      rd_mask = '0;
      wr_mask = '0;
    end
    if (ns) begin
      if (!mix_mode) begin
        // whole bank refused
        rd_mask = '0;
        wr_mask = '0;
        blk_err = 1'b1;
      end else begin
        case (cls)
          CL_SEC: begin
            rd_mask = '0;
            wr_mask = '0;
          end
          CL_NSEN: wr_mask = '0;
          CL_PIN: begin
            rd_mask = nsen;
            wr_mask = nsen;
          end
          CL_NONE: begin
            rd_mask = '0;
            wr_mask = '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/psaf_alias.sv
module psaf_alias
  import psaf_pkg::*;
#(
  parameter int W = 32
) (
  input  aop_e         op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] wdm,
  input  logic [W-1:0] wr_mask,
  output logic [W-1:0] nxt
);
  // wdm already carries the per-bit mask
  always_comb begin
    case (op)
      AOP_CLR: nxt = cur & ~wdm;
      AOP_SET: nxt = cur | wdm;
      AOP_TGL: nxt = cur ^ wdm;
      default: nxt = (cur & ~wr_mask) | wdm;
    endcase
  end
endmodule

// File: rtl/psaf_notify.sv
module psaf_notify #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         nsen_we,
  input  logic [W-1:0] nsen_old,
  input  logic [W-1:0] nsen_new,
  input  logic [W-1:0] chk,
  input  logic         flag_clr,
  input  logic         ie_set,
  input  logic         ie_clr,
  output logic         flag,
  output logic         ie,
  output logic         irq
);
  logic hit;

  assign hit = nsen_we && (|((nsen_old ^ nsen_new) & chk));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ie   <= 1'b0;
    end else begin
      if (hit)           flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (ie_set)        ie <= 1'b1;
      else if (ie_clr)   ie <= 1'b0;
    end
  end

  assign irq = flag & ie;
endmodule

// File: rtl/psaf_top.sv
module psaf_top
  import psaf_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mix_mode,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_ns,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          bus_err,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  ctrl_o,
  output logic [W-1:0]  evctl_o,
  output logic [W-1:0]  dir_o,
  output logic [W-1:0]  out_o,
  output logic [W-1:0]  pcfg_o,
  output logic [W-1:0]  pmux_o,
  output logic          irq
);
  localparam int NGRP = 2;

  rid_e         rid;
  cls_e         cls;
  logic [W-1:0] rd_mask, wr_mask, wdm, raw;
  logic         blk_err, bus_we;
  logic [W-1:0] ctrl_q, evctl_q, nsen_q, chk_q, pcfg_q, pmux_q, nsen_new;
  logic         nsen_we, flag_w, ie_w;
  logic [W-1:0] grp_q   [NGRP];
  logic [W-1:0] grp_nxt [NGRP];

  psaf_decode #(.AW(AW)) u_dec (.addr(bus_addr), .rid(rid), .cls(cls));

  psaf_gate #(.W(W)) u_gate (
    .mix_mode(mix_mode), .ns(bus_ns), .cls(cls), .nsen(nsen_q),
    .rd_mask(rd_mask), .wr_mask(wr_mask), .blk_err(blk_err)
  );

  assign bus_we   = bus_sel & bus_wr;
  assign wdm      = bus_wdata & wr_mask;
  assign nsen_new = (nsen_q & ~wr_mask) | wdm;
  assign nsen_we  = bus_we && (rid == R_NSEN);

  // direction and output groups, each with four aliases
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam rid_e BASE = (g == 0) ? R_DIR : R_OUT;
    int           k;
    logic         hit;
    aop_e         op;
    logic [W-1:0] r;

    always_comb begin
      k   = int'(rid) - int'(BASE);
      hit = bus_we && (k >= 0) && (k <= 3);
      op  = aop_e'(k[1:0]);
    end

    psaf_alias #(.W(W)) u_alias (
      .op(op), .cur(r), .wdm(wdm), .wr_mask(wr_mask), .nxt(grp_nxt[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r <= '0;
      else if (hit) r <= grp_nxt[g];
    end

    assign grp_q[g] = r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      evctl_q <= '0;
      nsen_q  <= '0;
      chk_q   <= '0;
      pcfg_q  <= '0;
      pmux_q  <= '0;
    end else if (bus_we) begin
      case (rid)
        R_CTRL:  ctrl_q  <= (ctrl_q  & ~wr_mask) | wdm;
        R_EVCTL: evctl_q <= (evctl_q & ~wr_mask) | wdm;
        R_NSEN:  nsen_q  <= nsen_new;
        R_CHK:   chk_q   <= (chk_q   & ~wr_mask) | wdm;
        R_PCFG:  pcfg_q  <= (pcfg_q  & ~wr_mask) | wdm;
        R_PMUX:  pmux_q  <= (pmux_q  & ~wr_mask) | wdm;
        default: ;
      endcase
    end
  end

  psaf_notify #(.W(W)) u_note (
    .clk(clk), .rst_n(rst_n),
    .nsen_we(nsen_we), .nsen_old(nsen_q), .nsen_new(nsen_new), .chk(chk_q),
    .flag_clr(bus_we && (rid == R_IFLAG) && wdm[0]),
    .ie_set(bus_we && (rid == R_ISET) && wdm[0]),
    .ie_clr(bus_we && (rid == R_ICLR) && wdm[0]),
    .flag(flag_w), .ie(ie_w), .irq(irq)
  );

  always_comb begin
    raw = '0;
    case (rid)
      R_CTRL:                       raw = ctrl_q;
      R_EVCTL:                      raw = evctl_q;
      R_NSEN:                       raw = nsen_q;
      R_CHK:                        raw = chk_q;
      R_ICLR, R_ISET:               raw[0] = ie_w;
      R_IFLAG:                      raw[0] = flag_w;
      R_DIR, R_DIRC, R_DIRS, R_DIRT: raw = grp_q[0];
      R_OUT, R_OUTC, R_OUTS, R_OUTT: raw = grp_q[1];
      R_IN:                         raw = pin_in;
      R_PCFG:                       raw = pcfg_q;
      R_PMUX:                       raw = pmux_q;
      default:                      raw = '0;
    endcase
  end

  assign bus_rdata = bus_sel ? (raw & rd_mask) : '0;
  assign bus_err   = bus_sel & blk_err;
  assign ctrl_o    = ctrl_q;
  assign evctl_o   = evctl_q;
  assign dir_o     = grp_q[0];
  assign out_o     = grp_q[1];
  assign pcfg_o    = pcfg_q;
  assign pmux_o    = pmux_q;
endmodule

// File: rtl/psaf_chk.sv
module psaf_chk #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mix_mode,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic          bus_ns,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_rdata,
  input logic          bus_err,
  input logic [W-1:0]  dir_o,
  input logic [W-1:0]  out_o,
  input logic [W-1:0]  nsen,
  input logic          nsen_we,
  input logic          flag,
  input logic          irq
);
  // R2 / R3: refused non-secure traffic always errors
  a_r3_fullsec_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_ns && !mix_mode) |-> bus_err);

  // R2: refused read returns zero
  a_r2_fullsec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_ns && !mix_mode) |-> (bus_rdata == '0));

  // R5 / R7 / R11: mixed mode never errors
  a_r5_mixed_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && mix_mode) |-> !bus_err);

  // R6: non-secure write leaves the enable word unchanged
  a_r6_nsen_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_ns && bus_addr == AW'(2)) |=> (nsen == $past(nsen)));

  // R7 / R8: non-secure writes never move secure pins
  a_r8_dir_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_ns) |=> (((dir_o ^ $past(dir_o)) & ~$past(nsen)) == '0));

  a_r8_out_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_ns) |=> (((out_o ^ $past(out_o)) & ~$past(nsen)) == '0));

  // R9: flag only rises after an enable-word write
  a_r9_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(nsen_we));

  // R10: interrupt needs the flag
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

bind psaf_top psaf_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mix_mode(mix_mode), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_ns(bus_ns), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .dir_o(dir_o), .out_o(out_o),
  .nsen(nsen_q), .nsen_we(nsen_we), .flag(flag_w), .irq(irq)
);

// File: tb/sim_psaf_top.sv
`timescale 1ns/1ps
module sim_psaf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mix_mode = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_ns = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0;
  logic [31:0] bus_rdata, ctrl_o, evctl_o, dir_o, out_o, pcfg_o, pmux_o;
  logic        bus_err, irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_ctrl = 0, m_ev = 0, m_nsen = 0, m_chk = 0;
  logic [31:0] m_dir = 0, m_out = 0, m_pcfg = 0, m_pmux = 0;
  bit m_ie = 0, m_flag = 0;

  always #4 clk = ~clk;

  psaf_top u0 (
    .clk(clk), .rst_n(rst_n), .mix_mode(mix_mode), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_ns(bus_ns), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .pin_in(pin_in), .ctrl_o(ctrl_o), .evctl_o(evctl_o), .dir_o(dir_o),
    .out_o(out_o), .pcfg_o(pcfg_o), .pmux_o(pmux_o), .irq(irq)
  );

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // 0 sec, 1 enable word, 2 open, 3 pin, 4 unmapped
  function automatic int cls_of(int a);
    if (a <= 1) return 0;
    if (a == 2) return 1;
    if (a >= 3 && a <= 6) return 2;
    if (a >= 8 && a <= 18) return 3;
    return 4;
  endfunction

  function automatic logic [31:0] rmask(bit ns, int a);
    int c = cls_of(a);
    if (c == 4) return 0;
    if (!ns) return '1;
    if (!mix_mode) return 0;
    case (c)
      0: return 0;
      3: return m_nsen;
      default: return '1;
    endcase
  endfunction

  function automatic logic [31:0] wmask(bit ns, int a);
    int c = cls_of(a);
    if (c == 4) return 0;
    if (!ns) return '1;
    if (!mix_mode) return 0;
    case (c)
      0, 1: return 0;
      3: return m_nsen;
      default: return '1;
    endcase
  endfunction

  function automatic logic [31:0] rawv(int a);
    case (a)
      0: return m_ctrl;
      1: return m_ev;
      2: return m_nsen;
      3: return m_chk;
      4, 5: return {31'b0, m_ie};
      6: return {31'b0, m_flag};
      8, 9, 10, 11: return m_dir;
      12, 13, 14, 15: return m_out;
      16: return pin_in;
      17: return m_pcfg;
      18: return m_pmux;
      default: return 0;
    endcase
  endfunction

  function automatic string tag(bit w, bit ns, int a);
    int c = cls_of(a);
    if (!ns) return "R1";
    if (!mix_mode) return w ? "R3" : "R2";
    case (c)
      0: return "R5";
      1: return "R6";
      2: return "R4";
      3: return ((a >= 9 && a <= 11) || (a >= 13 && a <= 15)) ? "R8" : "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic acc(input bit w, input bit ns, input int a, input logic [31:0] d);
    logic [31:0] rm, wm, dm, old;
    string t;
    @(negedge clk);
    bus_sel = 1; bus_wr = w; bus_ns = ns; bus_addr = 5'(a); bus_wdata = d;
    pin_in = $urandom;
    #1;
    rm = rmask(ns, a);
    wm = wmask(ns, a);
    t = tag(w, ns, a);
    if (!w) chk({t, " rdata"}, bus_rdata, rawv(a) & rm);
    chk({t, " err"}, {31'b0, bus_err}, {31'b0, ns && !mix_mode});
    @(posedge clk);
    #1;
    bus_sel = 0;
    if (w) begin
      dm = d & wm;
      case (a)
        0: m_ctrl = (m_ctrl & ~wm) | dm;
        1: m_ev = (m_ev & ~wm) | dm;
        2: begin
          old = m_nsen;
          m_nsen = (m_nsen & ~wm) | dm;
          if (((old ^ m_nsen) & m_chk) != 0) m_flag = 1;
        end
        3: m_chk = (m_chk & ~wm) | dm;
        4: if (dm[0]) m_ie = 0;
        5: if (dm[0]) m_ie = 1;
        6: if (dm[0]) m_flag = 0;
        8: m_dir = (m_dir & ~wm) | dm;
        9: m_dir = m_dir & ~dm;
        10: m_dir = m_dir | dm;
        11: m_dir = m_dir ^ dm;
        12: m_out = (m_out & ~wm) | dm;
        13: m_out = m_out & ~dm;
        14: m_out = m_out | dm;
        15: m_out = m_out ^ dm;
        17: m_pcfg = (m_pcfg & ~wm) | dm;
        18: m_pmux = (m_pmux & ~wm) | dm;
        default: ;
      endcase
      chk({t, " dir_o"}, dir_o, m_dir);
      chk({t, " out_o"}, out_o, m_out);
      chk({t, " ctrl_o"}, ctrl_o, m_ctrl);
      chk({t, " evctl_o"}, evctl_o, m_ev);
      chk({t, " pcfg_o"}, pcfg_o, m_pcfg);
      chk({t, " pmux_o"}, pmux_o, m_pmux);
    end
    chk((a == 2) ? "R9 irq" : "R10 irq", {31'b0, irq}, {31'b0, m_flag && m_ie});
  endtask

  task automatic random_phase(input int n);
    for (int i = 0; i < n; i++) begin
      int a = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 31))
                                          : int'($urandom_range(0, 18));
      acc(1'($urandom), 1'($urandom), a, $urandom);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 19; a++) if (a != 16) acc(0, 0, a, 0);
    chk("R1 reset irq", {31'b0, irq}, 0);

    // R9 / R10 directed, mixed mode
    acc(1, 0, 3, 32'h0000_000F);
    acc(1, 0, 2, 32'h0000_0100);   // outside mask: no flag (R9)
    acc(0, 1, 6, 0);
    acc(1, 0, 2, 32'h0000_01FF);   // inside mask: flag (R9)
    acc(1, 1, 5, 1);               // enable via non-secure (R4, R10)
    acc(1, 1, 2, 32'h0);           // dropped (R6)
    acc(0, 1, 2, 0);
    acc(1, 1, 11, 32'hFFFF_FFFF);  // toggle limited to open pins (R8)
    acc(1, 1, 8, 32'hFFFF_FFFF);   // R7
    acc(1, 1, 9, 32'hFFFF_FFFF);   // R8 clear
    acc(1, 0, 14, 32'hF0F0_F0F0);
    acc(1, 1, 15, 32'hFFFF_FFFF);
    acc(1, 1, 0, 32'hFFFF_FFFF);   // R5
    acc(1, 0, 0, 32'h1234_5678);
    acc(0, 1, 0, 0);
    acc(0, 1, 16, 0);              // R7 input
    acc(1, 1, 7, 32'hFFFF_FFFF);   // R11
    acc(0, 0, 25, 0);
    acc(1, 1, 6, 1);               // R10 clear flag
    acc(1, 1, 4, 1);               // R10 disable

    random_phase(700);
    mix_mode = 0;
    random_phase(250);
    mix_mode = 1;
    random_phase(300);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule